// File: doc/BRIEF.md
# Device IN Endpoint Transmit Controller

This block holds the control and status logic for a single device-side IN endpoint of a USB function. Software reaches it through one 8-bit control/status byte. It commits packets into a packet FIFO that is counted in whole-packet slots and is double-buffered by default. It can flush the most recent packet, request a STALL, and reset the data toggle. The protocol engine next to it reports abstract events: an IN token arrived, a data packet went out and was acknowledged, or a STALL handshake went out. The engine also reports whether the endpoint is isochronous. For each IN token the block decides the handshake, which is data, NAK or STALL. It keeps the endpoint interrupt flag and the data toggle bit.

Packet bytes, serialisation, CRC and token decoding live elsewhere. Only the packet count matters here. A software write of packet-ready stands for "one packet has been loaded".

All interfaces are plain level or pulse signals. Each control bit takes effect on the clock edge where it is sampled. Nothing at the edge of the block uses back-pressure.

Top module: `txep_ctrl`

## Requirements
- R1: After reset, rd_data is 0x00, irq is 0, data_toggle is 0 and resp is 0 (none).
- R2: Bit 0 (packet-ready) reads 1 exactly when every slot holds a packet (2 slots when DOUBLE_BUF=1, 1 otherwise). A write with bit 0 = 1 and bit 3 = 0 commits one packet if a slot is free, and is ignored if every slot is full. When double-buffered, the first commit therefore leaves bit 0 at 0.
- R3: Bit 1 (FIFO-not-empty) reads 1 exactly when at least one packet is held. Writes to it are ignored.
- R4: A pkt_sent pulse while a packet is held has three effects. It frees one slot. It sets irq. It inverts data_toggle unless iso_mode is 1. A pkt_sent pulse with the FIFO empty has no effect.
- R5: On an in_token pulse, resp in the next cycle encodes the handshake: 3 = STALL when send-stall is set and iso_mode is 0; otherwise 1 = data when a packet is held; otherwise 2 = NAK. In every other cycle resp is 0.
- R6: Bit 2 (underrun) is set by an in_token that finds the FIFO empty and is not answered with STALL. A write with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R7: Bit 4 (send-stall) reads back the last value written. It has no effect on the handshake while iso_mode is 1.
- R8: A stall_sent pulse sets bit 5 (stalled) and empties the FIFO. A pkt_sent pulse in the same cycle then has no effect. A write with bit 5 = 0 clears stalled and a write with bit 5 = 1 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R9: A write with bit 3 = 1 (flush) sets irq. With bit 0 = 0, it removes one packet if any is left after a same-cycle pkt_sent. With bit 0 = 1, the packet being loaded is abandoned and the slot count is unchanged. Bit 3 always reads 0.
- R10: A write with bit 6 = 1 forces data_toggle to 0, and this wins over a same-cycle flip. Bits 6 and 7 always read 0.
- R11: irq_clr clears irq. When a hardware set (R4, R9) arrives in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control/status byte |
| wr_data | input | 8 | Write data for the control/status byte |
| rd_data | output | 8 | Current control/status byte |
| irq_clr | input | 1 | Write-1-to-clear of the endpoint interrupt flag |
| in_token | input | 1 | IN token received for this endpoint (pulse) |
| pkt_sent | input | 1 | Data packet sent and acknowledged (pulse) |
| stall_sent | input | 1 | STALL handshake sent (pulse) |
| iso_mode | input | 1 | Endpoint is isochronous |
| resp | output | 2 | Handshake decision for the previous cycle's token: 0 none, 1 data, 2 NAK, 3 STALL |
| irq | output | 1 | Endpoint interrupt flag |
| data_toggle | output | 1 | Current data toggle |

## Verification
The bench builds the block with the default DOUBLE_BUF=1, so the FIFO has two slots. This brings several behaviours within reach:
- packet-ready auto-clearing after the first commit;
- a commit refused when both slots are full;
- the two flushes needed to empty the FIFO;
- a flush and a send in the same cycle draining both slots at once.

Directed sequences and a long pseudo-random run produce collisions inside one cycle: set against clear on underrun, stalled and irq; toggle clear against flip; stall against send. Isochronous mode is switched on and off during the run, so the stall bypass and the frozen toggle are also covered.

// File: rtl/txep_pkg.sv
package txep_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_DATA  = 2'd1,
    RSP_NAK   = 2'd2,
    RSP_STALL = 2'd3
  } txep_resp_e;

  localparam int B_RDY   = 0;
  localparam int B_NE    = 1;
  localparam int B_UNDR  = 2;
  localparam int B_FLUSH = 3;
  localparam int B_STALL = 4;
  localparam int B_STLD  = 5;
  localparam int B_CLRDT = 6;
endpackage

// File: rtl/txep_slots.sv
module txep_slots #(
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit_req,
  input  logic flush_req,
  input  logic sent,
  input  logic flush_all,
  output logic sent_eff,
  output logic full,
  output logic nonempty
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d, after_sent;
  logic commit_eff, flush_eff;

  always_comb begin
    sent_eff   = sent && (cnt_q != '0) && !flush_all;
    after_sent = sent_eff ? cnt_q - ONE : cnt_q;
    commit_eff = commit_req && !flush_req && (cnt_q < FULL_CNT);
    flush_eff  = flush_req && !commit_req && (after_sent != '0);
    cnt_d      = after_sent;
    if (commit_eff) cnt_d = cnt_d + ONE;
    if (flush_eff)  cnt_d = cnt_d - ONE;
    if (flush_all)  cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign full     = (cnt_q == FULL_CNT);
  assign nonempty = (cnt_q != '0);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  p_stall_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !nonempty);
  p_full_refuses_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !sent && !flush_req && !flush_all) |=> full);
endmodule

// File: rtl/txep_handshake.sv
module txep_handshake
  import txep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_token,
  input  logic       stall_act,
  input  logic       nonempty,
  output txep_resp_e resp,
  output logic       underrun_set
);
  txep_resp_e resp_d;

  always_comb begin
    resp_d = RSP_NONE;
    if (in_token) begin
      if (stall_act)     resp_d = RSP_STALL;
      else if (nonempty) resp_d = RSP_DATA;
      else               resp_d = RSP_NAK;
    end
  end

  assign underrun_set = in_token && !stall_act && !nonempty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp <= RSP_NONE;
    else        resp <= resp_d;
  end

  p_stall_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && stall_act) |=> (resp == RSP_STALL));
  p_idle_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_token |=> (resp == RSP_NONE));
endmodule

// File: rtl/txep_toggle.sv
module txep_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  input  logic clear,
  output logic toggle
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     toggle <= 1'b0;
    else if (clear) toggle <= 1'b0;
    else if (flip)  toggle <= ~toggle;
  end

  p_clr_dt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !toggle);
  p_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !clear) |=> (toggle != $past(toggle)));
endmodule

// File: rtl/txep_ctrl.sv
module txep_ctrl
  import txep_pkg::*;
#(
  parameter bit DOUBLE_BUF = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       irq_clr,
  input  logic       in_token,
  input  logic       pkt_sent,
  input  logic       stall_sent,
  input  logic       iso_mode,
  output logic [1:0] resp,
  output logic       irq,
  output logic       data_toggle
);
  localparam int DEPTH = DOUBLE_BUF ? 2 : 1;

  logic stall_q, stalled_q, underrun_q;
  logic commit_req, flush_req, clr_dt;
  logic sent_eff, full, nonempty, underrun_set, stall_act, irq_set;
  txep_resp_e resp_e;

  assign commit_req = wr_en && wr_data[B_RDY];
  assign flush_req  = wr_en && wr_data[B_FLUSH];
  assign clr_dt     = wr_en && wr_data[B_CLRDT];
  assign stall_act  = stall_q && !iso_mode;
  assign irq_set    = sent_eff || flush_req;

  txep_slots #(.DEPTH(DEPTH)) u_slots (
    .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .flush_req(flush_req),
    .sent(pkt_sent), .flush_all(stall_sent), .sent_eff(sent_eff),
    .full(full), .nonempty(nonempty)
  );

  txep_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .in_token(in_token), .stall_act(stall_act),
    .nonempty(nonempty), .resp(resp_e), .underrun_set(underrun_set)
  );

  txep_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .flip(sent_eff && !iso_mode), .clear(clr_dt),
    .toggle(data_toggle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q    <= 1'b0;
      stalled_q  <= 1'b0;
      underrun_q <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (wr_en) stall_q <= wr_data[B_STALL];

      if (stall_sent)                     stalled_q <= 1'b1;
      else if (wr_en && !wr_data[B_STLD]) stalled_q <= 1'b0;

      if (underrun_set)                   underrun_q <= 1'b1;
      else if (wr_en && !wr_data[B_UNDR]) underrun_q <= 1'b0;

      if (irq_set)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  always_comb begin
    rd_data         = 8'h00;
    rd_data[B_RDY]  = full;
    rd_data[B_NE]   = nonempty;
    rd_data[B_UNDR] = underrun_q;
    rd_data[B_STALL]= stall_q;
    rd_data[B_STLD] = stalled_q;
  end

  assign resp = resp_e;

  p_irq_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq);
  p_underrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_set |=> rd_data[B_UNDR]);
  p_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_sent |=> (rd_data[B_STLD] && !rd_data[B_RDY]));
endmodule

// File: tb/txep_ctrl_bench.sv
module txep_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, irq_clr = 1'b0, in_token = 1'b0;
  logic       pkt_sent = 1'b0, stall_sent = 1'b0, iso_mode = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [1:0] resp;
  logic       irq, data_toggle;

  int checks = 0, errors = 0, cycles = 0;
  int m_cnt, m_stall, m_stalled, m_undr, m_irq, m_tog, m_resp;
  localparam int SLOTS = 2;

  always #5 clk = ~clk;

  txep_ctrl u_txep_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_clr(irq_clr), .in_token(in_token),
    .pkt_sent(pkt_sent), .stall_sent(stall_sent), .iso_mode(iso_mode),
    .resp(resp), .irq(irq), .data_toggle(data_toggle)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    check("R2 packet-ready bit0", int'(rd_data[0]), (m_cnt == SLOTS) ? 1 : 0);
    check("R3 not-empty bit1", int'(rd_data[1]), (m_cnt > 0) ? 1 : 0);
    check("R6 underrun bit2", int'(rd_data[2]), m_undr);
    check("R9 flush bit3 reads 0", int'(rd_data[3]), 0);
    check("R7 send-stall bit4", int'(rd_data[4]), m_stall);
    check("R8 stalled bit5", int'(rd_data[5]), m_stalled);
    check("R10 bits 7:6 read 0", int'(rd_data[7:6]), 0);
    check("R5 handshake resp", int'(resp), m_resp);
    check("R11 irq", int'(irq), m_irq);
    check("R4 data toggle", int'(data_toggle), m_tog);
  endtask

  task automatic model_reset();
    m_cnt = 0; m_stall = 0; m_stalled = 0; m_undr = 0;
    m_irq = 0; m_tog = 0; m_resp = 0;
  endtask

  task automatic model_step(bit we, logic [7:0] wd, bit tok, bit snt, bit stl,
                            bit iso, bit iclr);
    int old, sent_e, commit, flush_e, rest;
    bit stall_act;
    old = m_cnt;
    stall_act = (m_stall != 0) && !iso;
    if (tok) m_resp = stall_act ? 3 : (old > 0 ? 1 : 2);
    else     m_resp = 0;
    sent_e  = (!stl && snt && old > 0) ? 1 : 0;
    rest    = old - sent_e;
    commit  = (we && wd[0] && !wd[3] && old < SLOTS) ? 1 : 0;
    flush_e = (we && wd[3] && !wd[0] && rest > 0) ? 1 : 0;
    m_cnt   = stl ? 0 : rest + commit - flush_e;
    if (tok && !stall_act && old == 0) m_undr = 1;
    else if (we && !wd[2])             m_undr = 0;
    if (stl)               m_stalled = 1;
    else if (we && !wd[5]) m_stalled = 0;
    if (we) m_stall = wd[4];
    if (sent_e == 1 || (we && wd[3])) m_irq = 1;
    else if (iclr)                    m_irq = 0;
    if (we && wd[6])              m_tog = 0;
    else if (sent_e == 1 && !iso) m_tog = 1 - m_tog;
  endtask

  task automatic step(bit we, logic [7:0] wd, bit tok, bit snt, bit stl,
                      bit iso, bit iclr);
    @(negedge clk);
    compare_all();
    wr_en = we; wr_data = wd; in_token = tok; pkt_sent = snt;
    stall_sent = stl; iso_mode = iso; irq_clr = iclr;
    @(posedge clk);
    model_step(we, wd, tok, snt, stl, iso, iclr);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 reset rd_data", int'(rd_data), 0);
    check("R1 reset irq", int'(irq), 0);
    check("R1 reset toggle", int'(data_toggle), 0);
    check("R1 reset resp", int'(resp), 0);

    // R6 underrun on empty token, R5 NAK
    step(0, 8'h00, 1, 0, 0, 0, 0);
    // R2 first commit leaves ready clear, second fills, third refused
    step(1, 8'h05, 0, 0, 0, 0, 0);
    step(1, 8'h05, 0, 0, 0, 0, 0);
    step(1, 8'h05, 1, 0, 0, 0, 0);
    // R4 sent frees slot, irq, flip; R11 clear against set
    step(0, 8'h00, 0, 1, 0, 0, 1);
    step(0, 8'h00, 0, 0, 0, 0, 1);
    // R9 flush twice empties
    step(1, 8'h01, 0, 0, 0, 0, 0);
    step(1, 8'h08, 0, 0, 0, 0, 0);
    step(1, 8'h08, 0, 0, 0, 0, 0);
    // R9 flush together with ready abandons load
    step(1, 8'h09, 0, 0, 0, 0, 0);
    // R7 stall ignored in iso, R8 stall sent empties
    step(1, 8'h11, 0, 0, 0, 0, 0);
    step(0, 8'h00, 1, 0, 0, 1, 0);
    step(0, 8'h00, 1, 0, 0, 0, 0);
    step(0, 8'h00, 0, 1, 1, 0, 0);
    step(1, 8'h00, 0, 0, 1, 0, 0);
    step(1, 8'h00, 0, 0, 0, 0, 0);
    // R10 toggle clear wins over flip
    step(1, 8'h01, 0, 0, 0, 0, 0);
    step(1, 8'h40, 0, 1, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      bit we, tok, snt, stl, iso, iclr;
      logic [7:0] wd;
      we   = ($urandom_range(0, 4) == 0);
      wd   = 8'($urandom);
      tok  = ($urandom_range(0, 3) == 0);
      snt  = ($urandom_range(0, 2) == 0);
      stl  = ($urandom_range(0, 24) == 0);
      iso  = ($urandom_range(0, 7) == 0);
      iclr = ($urandom_range(0, 5) == 0);
      step(we, wd, tok, snt, stl, iso, iclr);
    end
    @(negedge clk);
    compare_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule